// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block turns a software write of a 16-bit command word into one request on an abstract SD command channel. It carries the 6-bit command index and a 32-bit argument. The channel answers with a single pulse that carries a byte count and a 128-bit payload. The block checks that byte count against the response kind that the command word asked for. If the count fits, it files the payload into four 32-bit response words. If it does not fit, it marks the command as failed and raises a command-timeout status bit. For a command flagged as busy-wait, a completed exchange can also raise a busy-done status bit.

Only one command is in flight at a time. While a command is pending, writes to the command word and to the argument are dropped. A response pulse that arrives while nothing is pending is also dropped. Completion clears the new-command flag in the stored command word and produces a one-cycle acknowledge toward the channel.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset the stored command word, the argument, all four response words, both status bits, `req_valid` and `rsp_ack` are zero.
- R2: A command write while idle stores all 16 bits in `cmd_reg`. If bit 15 (new) is set, `req_valid` is high from the next cycle, with `req_index` equal to bits 5:0 and `req_arg` equal to the stored argument. If bit 15 is clear, no request starts.
- R3: While `req_valid` is high, command and argument writes are ignored: `cmd_reg`, `req_index` and `req_arg` keep their values.
- R4: A `rsp_valid` pulse while no command is pending changes nothing: no acknowledge, and the response words and `cmd_reg` are unchanged.
- R5: The response is faulty when bit 10 (no-response) is clear and any of these holds: the length is 0; the length is 4 and bit 9 (long) is set; the length is neither 4 nor 16. A faulty response sets `cmd_reg` bit 14 (fail) and `stat_timeout`, and leaves the response words unchanged.
- R6: A length of 4 without a fault loads word 0 with payload bytes 0..3, big-endian, and clears words 1..3. Byte 0 is `rsp_data[127:120]` and byte k is `rsp_data[127-8k -: 8]`.
- R7: A length of 16 without a fault loads word 3 from bytes 0..3, word 2 from bytes 4..7, word 1 from bytes 8..11 and word 0 from bytes 12..15, each big-endian. Word j appears at `rsp_words[32j+31:32j]`.
- R8: With bit 10 (no-response) set, every length is accepted without a fault, and the response words are unchanged.
- R9: A response that arrives while a command is pending completes it. From the next cycle `cmd_reg` bit 15 is clear, `req_valid` is low, and `rsp_ack` is high for exactly one cycle.
- R10: `stat_busy` is set on completion when the response has no fault, `cmd_reg` bit 11 (busy-wait) is set and `cfg_busy_irq_en` is high. It is set at no other time.
- R11: `stat_clr` bit 0 clears `stat_timeout` and bit 1 clears `stat_busy`. When a clear and a set of the same bit fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word write data |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument write data |
| cfg_busy_irq_en | input | 1 | Enable for the busy-done status bit |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 timeout, bit 1 busy |
| cmd_reg | output | 16 | Stored command word |
| stat_timeout | output | 1 | Command-timeout status (sticky) |
| stat_busy | output | 1 | Busy-done status (sticky) |
| rsp_words | output | 128 | Response words, word j at [32j+31:32j] |
| req_valid | output | 1 | Command request pending on the channel |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Response pulse from the channel |
| rsp_len | input | 5 | Response length in bytes |
| rsp_data | input | 128 | Response payload, byte 0 in the top bits |
| rsp_ack | output | 1 | One-cycle acknowledge after a completion |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a response that completes the pending command and a software write-one-to-clear of the status bit that the same response sets. The bench drives both in one cycle and expects the set to win. The second pair is a command or argument write arriving while a response is still awaited. The bench drives these on every fourth sweep step and expects the stored word, the index and the argument to stay as they were. The main sweep runs all 32 lengths against all 16 combinations of the no-response, long, busy-wait and enable bits. Each outcome is judged against fault and storage rules computed in the bench.

// File: rtl/sdci_pkg.sv
package sdci_pkg;
  localparam int CMD_W   = 16;
  localparam int IDX_W   = 6;
  localparam int B_NEW   = 15;
  localparam int B_FAIL  = 14;
  localparam int B_BUSY  = 11;
  localparam int B_NORSP = 10;
  localparam int B_LONG  = 9;

  typedef struct packed {
    logic             busy;
    logic             no_rsp;
    logic             long_rsp;
    logic [IDX_W-1:0] idx;
  } cmd_fields_t;

  function automatic cmd_fields_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_fields_t f;
    f.busy     = c[B_BUSY];
    f.no_rsp   = c[B_NORSP];
    f.long_rsp = c[B_LONG];
    f.idx      = c[IDX_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/sdci_cmd_ctrl.sv
module sdci_cmd_ctrl
  import sdci_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             arg_wr,
  input  logic [ARG_W-1:0] arg_wdata,
  input  logic             done,
  input  logic             done_fail,
  output logic [CMD_W-1:0] cmd_q,
  output logic [ARG_W-1:0] arg_q,
  output logic             pending,
  output logic             issue_evt
);
  logic cmd_take;
  logic arg_take;

  assign cmd_take  = cmd_wr & ~pending;
  assign arg_take  = arg_wr & ~pending;
  assign issue_evt = cmd_take & cmd_wdata[B_NEW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      arg_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (cmd_take) begin
        cmd_q <= cmd_wdata;
      end else if (done) begin
        cmd_q[B_NEW] <= 1'b0;
        if (done_fail) cmd_q[B_FAIL] <= 1'b1;
      end
      if (arg_take) arg_q <= arg_wdata;
      if (issue_evt) pending <= 1'b1;
      else if (done) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdci_rsp_judge.sv
module sdci_rsp_judge #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5
) (
  input  logic                        no_rsp,
  input  logic                        long_rsp,
  input  logic [LEN_W-1:0]            rsp_len,
  input  logic [WORD_W*N_WORDS-1:0]   rsp_data,
  input  logic [WORD_W*N_WORDS-1:0]   cur_words,
  output logic                        bad,
  output logic [WORD_W*N_WORDS-1:0]   next_words
);
  localparam int RSP_W     = WORD_W * N_WORDS;
  localparam int SHORT_LEN = WORD_W / 8;
  localparam int LONG_LEN  = RSP_W / 8;

  function automatic logic len_fault(input logic nr, input logic lg,
                                     input logic [LEN_W-1:0] len);
    if (nr) return 1'b0;
    if (len == LEN_W'(SHORT_LEN)) return lg;
    if (len == LEN_W'(LONG_LEN)) return 1'b0;
    return 1'b1;
  endfunction

  logic is_short;
  assign bad      = len_fault(no_rsp, long_rsp, rsp_len);
  assign is_short = (rsp_len == LEN_W'(SHORT_LEN));

  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    logic [WORD_W-1:0] short_w;
    logic [WORD_W-1:0] long_w;
    if (j == 0) begin : g_first
      assign short_w = rsp_data[RSP_W-1 -: WORD_W];
    end else begin : g_rest
      assign short_w = '0;
    end
    assign long_w = rsp_data[j*WORD_W +: WORD_W];
    always_comb begin
      if (no_rsp || bad) next_words[j*WORD_W +: WORD_W] = cur_words[j*WORD_W +: WORD_W];
      else if (is_short) next_words[j*WORD_W +: WORD_W] = short_w;
      else next_words[j*WORD_W +: WORD_W] = long_w;
    end
  end
endmodule

// File: rtl/sdci_rsp_store.sv
module sdci_rsp_store #(
  parameter int RSP_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             bad,
  input  logic             busy_req,
  input  logic             busy_en,
  input  logic [RSP_W-1:0] next_words,
  input  logic [1:0]       clr,
  output logic [RSP_W-1:0] words_q,
  output logic             stat_timeout,
  output logic             stat_busy,
  output logic             ack,
  output logic             busy_evt
);
  logic fail_evt;
  assign fail_evt = done & bad;
  assign busy_evt = done & ~bad & busy_req & busy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q      <= '0;
      stat_timeout <= 1'b0;
      stat_busy    <= 1'b0;
      ack          <= 1'b0;
    end else begin
      if (done) words_q <= next_words;
      stat_timeout <= (stat_timeout & ~clr[0]) | fail_evt;
      stat_busy    <= (stat_busy & ~clr[1]) | busy_evt;
      ack          <= done;
    end
  end
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sdci_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5,
  parameter int ARG_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_wr,
  input  logic [15:0]               cmd_wdata,
  input  logic                      arg_wr,
  input  logic [ARG_W-1:0]          arg_wdata,
  input  logic                      cfg_busy_irq_en,
  input  logic [1:0]                stat_clr,
  output logic [15:0]               cmd_reg,
  output logic                      stat_timeout,
  output logic                      stat_busy,
  output logic [WORD_W*N_WORDS-1:0] rsp_words,
  output logic                      req_valid,
  output logic [5:0]                req_index,
  output logic [ARG_W-1:0]          req_arg,
  input  logic                      rsp_valid,
  input  logic [LEN_W-1:0]          rsp_len,
  input  logic [WORD_W*N_WORDS-1:0] rsp_data,
  output logic                      rsp_ack
);
  localparam int RSP_W = WORD_W * N_WORDS;

  cmd_fields_t        fields;
  logic               pending;
  logic               issue_evt;
  logic               done_evt;
  logic               bad;
  logic               busy_evt;
  logic [RSP_W-1:0]   next_words;

  assign done_evt = pending & rsp_valid;
  assign fields   = decode_cmd(cmd_reg);

  sdci_cmd_ctrl #(.ARG_W(ARG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata),
    .done(done_evt), .done_fail(bad),
    .cmd_q(cmd_reg), .arg_q(req_arg),
    .pending(pending), .issue_evt(issue_evt)
  );

  sdci_rsp_judge #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .LEN_W(LEN_W)) u_judge (
    .no_rsp(fields.no_rsp), .long_rsp(fields.long_rsp),
    .rsp_len(rsp_len), .rsp_data(rsp_data),
    .cur_words(rsp_words), .bad(bad), .next_words(next_words)
  );

  sdci_rsp_store #(.RSP_W(RSP_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .done(done_evt), .bad(bad),
    .busy_req(fields.busy), .busy_en(cfg_busy_irq_en),
    .next_words(next_words), .clr(stat_clr),
    .words_q(rsp_words), .stat_timeout(stat_timeout),
    .stat_busy(stat_busy), .ack(rsp_ack), .busy_evt(busy_evt)
  );

  assign req_valid = pending;
  assign req_index = fields.idx;
endmodule

// File: rtl/sdci_checks.sv
module sdci_checks #(
  parameter int RSP_W = 128,
  parameter int ARG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_ack,
  input logic [15:0]      cmd_reg,
  input logic [5:0]       req_index,
  input logic [ARG_W-1:0] req_arg,
  input logic [RSP_W-1:0] rsp_words,
  input logic             stat_timeout,
  input logic             stat_busy
);
  p_req_has_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cmd_reg[15]);

  p_hold_while_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> ($stable(cmd_reg) && $stable(req_arg) && $stable(req_index)));

  p_idle_rsp_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && rsp_valid) |=> !rsp_ack);

  p_words_change_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ack |-> $stable(rsp_words));

  p_timeout_from_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_timeout) |-> rsp_ack);

  p_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid) |=> (!req_valid && rsp_ack && !cmd_reg[15]));

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  p_busy_from_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_busy) |-> rsp_ack);
endmodule

bind sd_cmd_issuer sdci_checks #(.RSP_W(WORD_W*N_WORDS), .ARG_W(ARG_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_ack(rsp_ack), .cmd_reg(cmd_reg), .req_index(req_index), .req_arg(req_arg),
  .rsp_words(rsp_words), .stat_timeout(stat_timeout), .stat_busy(stat_busy)
);

// File: tb/test_sd_cmd_issuer.sv
module test_sd_cmd_issuer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [15:0]  cmd_wdata = '0;
  logic         arg_wr = 1'b0;
  logic [31:0]  arg_wdata = '0;
  logic         cfg_busy_irq_en = 1'b0;
  logic [1:0]   stat_clr = '0;
  logic [15:0]  cmd_reg;
  logic         stat_timeout, stat_busy;
  logic [127:0] rsp_words;
  logic         req_valid;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid = 1'b0;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         rsp_ack;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [127:0] exp_words = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issuer i_sd_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata), .cfg_busy_irq_en(cfg_busy_irq_en),
    .stat_clr(stat_clr), .cmd_reg(cmd_reg), .stat_timeout(stat_timeout),
    .stat_busy(stat_busy), .rsp_words(rsp_words), .req_valid(req_valid),
    .req_index(req_index), .req_arg(req_arg), .rsp_valid(rsp_valid),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .rsp_ack(rsp_ack)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic fault_of(input logic nr, input logic lg, input int len);
    if (nr) return 1'b0;
    return !((len == 16) || (len == 4 && !lg));
  endfunction

  task automatic issue(input logic [15:0] c);
    cmd_wr = 1'b1; cmd_wdata = c;
    tick();
    cmd_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 cmd_reg", 128'(cmd_reg), 128'h0);
    chk("R1 words", rsp_words, 128'h0);
    chk("R1 status", 128'({stat_timeout, stat_busy}), 128'h0);
    chk("R1 req/ack", 128'({req_valid, rsp_ack}), 128'h0);
    chk("R1 arg", 128'(req_arg), 128'h0);

    // R2 write without new flag: stored, no request
    issue(16'h0203);
    chk("R2 stored no-new", 128'(cmd_reg), 128'h0203);
    chk("R2 no request", 128'(req_valid), 128'h0);

    // R4 response while idle is dropped
    rsp_valid = 1'b1; rsp_len = 5'd16; rsp_data = {4{32'hDEADBEEF}};
    tick();
    rsp_valid = 1'b0; rsp_data = '0;
    chk("R4 no ack", 128'(rsp_ack), 128'h0);
    chk("R4 words kept", rsp_words, exp_words);
    chk("R4 cmd kept", 128'(cmd_reg), 128'h0203);

    // Sweep: every length against every flag combination
    for (int len = 0; len < 32; len++) begin
      for (int c = 0; c < 16; c++) begin
        logic nr, lg, bw, en, err;
        logic [15:0]  cw;
        logic [31:0]  a;
        logic [127:0] d;
        nr = c[0]; lg = c[1]; bw = c[2]; en = c[3];
        a  = 32'h1357_0000 + 32'(len * 16 + c);
        cw = 16'h8000 | (16'(bw) << 11) | (16'(nr) << 10) | (16'(lg) << 9)
             | 16'((len * 16 + c) % 64);
        for (int j = 0; j < 4; j++) d[32*j +: 32] = 32'h1000_0000 * (j + 1) + 32'(len * 256 + c * 4 + j);
        cfg_busy_irq_en = en;
        stat_clr = 2'b11; arg_wr = 1'b1; arg_wdata = a;
        tick();
        stat_clr = 2'b00; arg_wr = 1'b0;
        issue(cw);
        chk("R2 request valid", 128'(req_valid), 128'h1);
        chk("R2 request index", 128'(req_index), 128'(cw[5:0]));
        chk("R2 request arg", 128'(req_arg), 128'(a));
        if (len % 4 == 1) begin
          cmd_wr = 1'b1; cmd_wdata = ~cw; arg_wr = 1'b1; arg_wdata = ~a;
          tick();
          cmd_wr = 1'b0; arg_wr = 1'b0;
          chk("R3 cmd kept", 128'(cmd_reg), 128'(cw));
          chk("R3 arg kept", 128'(req_arg), 128'(a));
          chk("R3 index kept", 128'(req_index), 128'(cw[5:0]));
        end
        rsp_valid = 1'b1; rsp_len = 5'(len); rsp_data = d;
        tick();
        rsp_valid = 1'b0; rsp_data = '0;
        err = fault_of(nr, lg, len);
        if (!err && !nr) begin
          if (len == 4) exp_words = {96'h0, d[127:96]};
          else exp_words = d;
        end
        chk("R9 req dropped", 128'(req_valid), 128'h0);
        chk("R9 ack high", 128'(rsp_ack), 128'h1);
        chk("R5 fail flag and new cleared", 128'(cmd_reg), 128'((cw & 16'h7FFF) | (err ? 16'h4000 : 16'h0)));
        chk("R5 timeout status", 128'(stat_timeout), 128'(err));
        chk("R10 busy status", 128'(stat_busy), 128'(!err && bw && en));
        if (nr) chk("R8 words kept", rsp_words, exp_words);
        else if (err) chk("R5 words kept", rsp_words, exp_words);
        else if (len == 4) chk("R6 short words", rsp_words, exp_words);
        else chk("R7 long words", rsp_words, exp_words);
        tick();
        chk("R9 ack single", 128'(rsp_ack), 128'h0);
      end
    end

    // R11 clear and set in the same cycle: set wins
    stat_clr = 2'b11;
    tick();
    stat_clr = 2'b00;
    chk("R11 cleared", 128'({stat_timeout, stat_busy}), 128'h0);
    issue(16'h8005);
    rsp_valid = 1'b1; rsp_len = 5'd0; stat_clr = 2'b01;
    tick();
    rsp_valid = 1'b0; stat_clr = 2'b00;
    chk("R11 set wins", 128'(stat_timeout), 128'h1);
    stat_clr = 2'b10;
    tick();
    stat_clr = 2'b00;
    chk("R11 other bit clear only", 128'(stat_timeout), 128'h1);
    stat_clr = 2'b01;
    tick();
    stat_clr = 2'b00;
    chk("R11 timeout cleared", 128'(stat_timeout), 128'h0);
    cfg_busy_irq_en = 1'b1;
    issue(16'h8800 | 16'h0011);
    rsp_valid = 1'b1; rsp_len = 5'd4; rsp_data = {32'hCAFEF00D, 96'h0}; stat_clr = 2'b10;
    tick();
    rsp_valid = 1'b0; stat_clr = 2'b00;
    chk("R11 busy set wins", 128'(stat_busy), 128'h1);
    chk("R6 short word0", rsp_words, 128'hCAFEF00D);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule